// File: doc/BRIEF.md
# Accumulator ALU with carry flag

This block holds an 8-bit accumulator and a single carry/borrow flag. The flag is one bit: a carry after an add, and the inverse of a borrow after a subtract. The host presents an opcode and a memory operand and raises a one-cycle start strobe. The operand is the byte addressed through a register pointer that lives outside this block. On the next clock edge the block updates the accumulator and the flag.

Every operation that reads memory also asks for the pointer to be post-incremented. It does this with a one-cycle request pulse that rises at the same edge as the result. A done pulse follows one cycle later.

The block offers the following operations:
- load
- bitwise OR, AND and XOR
- add
- subtract in both orders: operand minus accumulator, and accumulator minus operand
- shift-left of the accumulator, which reads no memory

The register file, the instruction decoder and the memory are outside the block.

Top module: `acc_unit`

## Requirements
- R1: After reset is released, the outputs read as follows: `acc_o` = 0, `flag_o` = 0, `done_o` = 0 and `ptr_inc_o` = 0.
- R2: Opcode 0 (load) copies `mem_i` into the accumulator.
- R3: Opcodes 1, 2 and 3 write the bitwise OR, AND and XOR of `mem_i` with the accumulator into the accumulator.
- R4: Opcodes 0 to 3 (those with opcode bit 2 clear) leave `flag_o` unchanged.
- R5: Opcode 4 writes the low 8 bits of `mem_i` + accumulator into the accumulator and writes the carry out into `flag_o`.
- R6: Opcode 5 writes `mem_i` − accumulator (mod 256) into the accumulator. It sets `flag_o` = 1 when `mem_i` ≥ accumulator (no borrow) and 0 otherwise.
- R7: Opcode 7 writes accumulator − `mem_i` (mod 256) into the accumulator. It sets `flag_o` = 1 when accumulator ≥ `mem_i` and 0 otherwise.
- R8: Opcode 6 moves accumulator bit 7 into `flag_o` and shifts the accumulator left, filling bit 0 with 0.
- R9: `mem_rd_o` is high exactly in a cycle where `start_i` is high with an opcode other than 6. A shift-left never reads memory and never raises `ptr_inc_o`.
- R10: For every opcode except 6, `ptr_inc_o` is high for the one cycle after the edge that samples `start_i`.
- R11: The result is visible right after the edge that samples `start_i`. `done_o` is high for the following cycle.
- R12: While `start_i` is low, the accumulator and the flag hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle operation strobe |
| op_i | input | 3 | Opcode select |
| mem_i | input | 8 | Memory operand |
| mem_rd_o | output | 1 | Memory read enable for the current cycle |
| acc_o | output | 8 | Accumulator |
| flag_o | output | 1 | Carry/borrow flag |
| ptr_inc_o | output | 1 | Pointer post-increment request |
| done_o | output | 1 | Completion pulse |

## Verification
The assertions run on every cycle and cover the following:
- the shift and load results
- the flag holding across load and the bitwise operations
- the read and increment behaviour of a shift
- the increment pulse and the done latency
- the hold while idle

The bench scenarios are the only place where the arithmetic values are shown correct. These are the carry out of an add at and around the overflow boundary, and the borrow polarity in both subtraction orders. The bench scenarios also check the bitwise results against a reference accumulator, and back-to-back strobes.

// File: rtl/acc_pkg.sv
package acc_pkg;
  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_OR    = 3'd1,
    OP_AND   = 3'd2,
    OP_XOR   = 3'd3,
    OP_ADD   = 3'd4,
    OP_SUBMD = 3'd5,
    OP_SHL   = 3'd6,
    OP_SUBDM = 3'd7
  } acc_op_e;

  function automatic logic op_reads_mem(acc_op_e op);
    return op != OP_SHL;
  endfunction

  function automatic logic op_writes_flag(acc_op_e op);
    return op[2];
  endfunction
endpackage

// File: rtl/acc_addsub.sv
module acc_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0]   c;
  logic [W-1:0] yy;

  assign c[0] = sub_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign yy[i]    = y_i[i] ^ sub_i;
    assign sum_o[i] = x_i[i] ^ yy[i] ^ c[i];
    assign c[i+1]   = (x_i[i] & yy[i]) | (c[i] & (x_i[i] ^ yy[i]));
  end

  assign cout_o = c[W];
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int W = 8
) (
  input  acc_op_e      op_i,
  input  logic [W-1:0] mem_i,
  input  logic [W-1:0] acc_i,
  input  logic         flag_i,
  output logic [W-1:0] res_o,
  output logic         flag_o
);
  logic [W-1:0] ax, ay, asum;
  logic         asub, acout;

  // operand steering: the subtract order decides which side is inverted
  always_comb begin
    ax   = mem_i;
    ay   = acc_i;
    asub = 1'b0;
    unique case (op_i)
      OP_SUBMD: asub = 1'b1;
      OP_SUBDM: begin ax = acc_i; ay = mem_i; asub = 1'b1; end
      default: ;
    endcase
  end

  acc_addsub #(.W(W)) u_addsub (
    .x_i(ax), .y_i(ay), .sub_i(asub), .sum_o(asum), .cout_o(acout)
  );

  always_comb begin
    res_o  = acc_i;
    flag_o = flag_i;
    unique case (op_i)
      OP_LOAD:  res_o = mem_i;
      OP_OR:    res_o = mem_i | acc_i;
      OP_AND:   res_o = mem_i & acc_i;
      OP_XOR:   res_o = mem_i ^ acc_i;
      OP_ADD, OP_SUBMD, OP_SUBDM: begin
        res_o  = asum;
        flag_o = acout;
      end
      OP_SHL: begin
        res_o  = {acc_i[W-2:0], 1'b0};
        flag_o = acc_i[W-1];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl #(
  parameter int DONE_LAT = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic reads_mem_i,
  output logic ptr_inc_o,
  output logic done_o
);
  localparam int STAGES = DONE_LAT + 1;

  logic [STAGES-1:0] pipe_q;
  logic              inc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
      inc_q  <= 1'b0;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], start_i};
      inc_q  <= start_i & reads_mem_i;
    end
  end

  assign ptr_inc_o = inc_q;
  assign done_o    = pipe_q[STAGES-1];

  // R11
  a_r11_done_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> ##1 done_o);
  // R10
  a_r10_inc_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && reads_mem_i) |=> ptr_inc_o);
  a_r10_no_inc_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !ptr_inc_o);
endmodule

// File: rtl/acc_unit.sv
module acc_unit
  import acc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] mem_i,
  output logic         mem_rd_o,
  output logic [W-1:0] acc_o,
  output logic         flag_o,
  output logic         ptr_inc_o,
  output logic         done_o
);
  acc_op_e      op;
  logic [W-1:0] acc_q, res;
  logic         flag_q, flag_n, reads_mem;

  assign op        = acc_op_e'(op_i);
  assign reads_mem = op_reads_mem(op);
  assign mem_rd_o  = start_i & reads_mem;

  acc_alu #(.W(W)) u_alu (
    .op_i(op), .mem_i(mem_i), .acc_i(acc_q), .flag_i(flag_q),
    .res_o(res), .flag_o(flag_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      flag_q <= 1'b0;
    end else if (start_i) begin
      acc_q  <= res;
      flag_q <= flag_n;
    end
  end

  acc_ctrl #(.DONE_LAT(1)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .reads_mem_i(reads_mem), .ptr_inc_o(ptr_inc_o), .done_o(done_o)
  );

  assign acc_o  = acc_q;
  assign flag_o = flag_q;

  // R2
  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 3'd0) |=> acc_o == $past(mem_i));
  // R4
  a_r4_flag_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !op_i[2]) |=> flag_o == $past(flag_o));
  // R8
  a_r8_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 3'd6) |=>
      (acc_o == {$past(acc_o[W-2:0]), 1'b0} && flag_o == $past(acc_o[W-1])));
  // R9
  a_r9_shift_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 3'd6) |-> !mem_rd_o);
  a_r9_shift_no_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 3'd6) |=> !ptr_inc_o);
  // R12
  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(acc_o) && $stable(flag_o)));
endmodule

// File: tb/acc_unit_tb.sv
module acc_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [2:0] op_i = '0;
  logic [7:0] mem_i = '0;
  logic       mem_rd_o, flag_o, ptr_inc_o, done_o;
  logic [7:0] acc_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] ref_acc = '0;
  logic       ref_flag = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  acc_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .mem_i(mem_i), .mem_rd_o(mem_rd_o), .acc_o(acc_o), .flag_o(flag_o),
    .ptr_inc_o(ptr_inc_o), .done_o(done_o)
  );

  task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic void model(logic [2:0] op, logic [7:0] m);
    logic [8:0] t;
    case (op)
      3'd0: ref_acc = m;
      3'd1: ref_acc = ref_acc | m;
      3'd2: ref_acc = ref_acc & m;
      3'd3: ref_acc = ref_acc ^ m;
      3'd4: begin t = {1'b0, m} + {1'b0, ref_acc}; ref_acc = t[7:0]; ref_flag = t[8]; end
      3'd5: begin ref_flag = (m >= ref_acc); ref_acc = m - ref_acc; end
      3'd7: begin ref_flag = (ref_acc >= m); ref_acc = ref_acc - m; end
      default: begin ref_flag = ref_acc[7]; ref_acc = {ref_acc[6:0], 1'b0}; end
    endcase
  endfunction

  function automatic string tag(logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1, 3'd2, 3'd3: return "R3";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  // one operation, with strobe, result, increment and done checked
  task automatic do_op(logic [2:0] op, logic [7:0] m);
    @(negedge clk_i);
    start_i = 1'b1; op_i = op; mem_i = m;
    #1 chk("R9 mem_rd", {8'h0, mem_rd_o}, {8'h0, (op != 3'd6)});
    model(op, m);
    @(negedge clk_i);
    start_i = 1'b0; mem_i = 8'h5a;
    chk(tag(op), {1'b0, acc_o}, {1'b0, ref_acc});
    if (op[2]) chk(tag(op), {8'h0, flag_o}, {8'h0, ref_flag});
    else chk("R4 flag kept", {8'h0, flag_o}, {8'h0, ref_flag});
    if (op == 3'd6) chk("R9 no ptr_inc", {8'h0, ptr_inc_o}, 9'h0);
    else chk("R10 ptr_inc", {8'h0, ptr_inc_o}, 9'h1);
    chk("R11 done early", {8'h0, done_o}, 9'h0);
    @(negedge clk_i);
    chk("R11 done", {8'h0, done_o}, 9'h1);
    chk("R10 ptr_inc width", {8'h0, ptr_inc_o}, 9'h0);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 acc", {1'b0, acc_o}, 9'h0);
    chk("R1 flag", {8'h0, flag_o}, 9'h0);
    chk("R1 done", {8'h0, done_o}, 9'h0);
    chk("R1 ptr_inc", {8'h0, ptr_inc_o}, 9'h0);
    ref_acc = '0; ref_flag = 1'b0;
  endtask

  task automatic t_logic();
    do_op(3'd0, 8'hc3);
    do_op(3'd1, 8'h14);
    do_op(3'd2, 8'h3c);
    do_op(3'd3, 8'hff);
  endtask

  task automatic t_add();
    do_op(3'd0, 8'h01);
    do_op(3'd4, 8'h02);
    do_op(3'd4, 8'hfd);
    do_op(3'd4, 8'hff);
    do_op(3'd3, 8'h00); // R4: flag from last add must survive
  endtask

  task automatic t_sub();
    do_op(3'd0, 8'h10);
    do_op(3'd5, 8'h30);
    do_op(3'd5, 8'h05);
    do_op(3'd0, 8'h40);
    do_op(3'd7, 8'h40);
    do_op(3'd7, 8'h01);
    do_op(3'd0, 8'h22);
    do_op(3'd7, 8'h10);
  endtask

  task automatic t_shift();
    do_op(3'd0, 8'h81);
    do_op(3'd6, 8'h00);
    do_op(3'd6, 8'hff);
    do_op(3'd2, 8'hff);
  endtask

  task automatic t_idle();
    logic [7:0] a;
    logic       f;
    a = acc_o; f = flag_o;
    @(negedge clk_i);
    op_i = 3'd0; mem_i = 8'h99;
    repeat (3) @(negedge clk_i);
    chk("R12 acc hold", {1'b0, acc_o}, {1'b0, a});
    chk("R12 flag hold", {8'h0, flag_o}, {8'h0, f});
  endtask

  task automatic t_back2back();
    @(negedge clk_i);
    start_i = 1'b1; op_i = 3'd0; mem_i = 8'h7f; model(3'd0, 8'h7f);
    @(negedge clk_i);
    op_i = 3'd4; mem_i = 8'h01; model(3'd4, 8'h01);
    chk("R2 b2b", {1'b0, acc_o}, 9'h07f);
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R5 b2b", {ref_flag, acc_o}, {1'b0, 8'h80});
    chk("R11 b2b done", {8'h0, done_o}, 9'h1);
    @(negedge clk_i);
    chk("R11 b2b done2", {8'h0, done_o}, 9'h1);
    @(negedge clk_i);
    chk("R11 b2b done end", {8'h0, done_o}, 9'h0);
  endtask

  initial begin
    t_reset();
    t_logic();
    t_add();
    t_sub();
    t_shift();
    t_idle();
    t_back2back();
    repeat (2) @(negedge clk_i);
    summary();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end
endmodule